// File: doc/BRIEF.md
# Sensor SPI Frame Master

This block drives a serial rate-sensor converter over SPI, one fixed conversion frame at a time. A host raises a request together with a channel address, a control-register update flag and an output-coding choice. The block lowers chip select and shifts a 16-bit control word out most significant bit first. On the same 16 serial clocks it shifts in the 16-bit result word. When the frame closes it returns the 12-bit sample and the 2-bit channel address echoed by the device, with a one-cycle done pulse.

The serial clock comes from the system clock through a programmable half-period count, and it idles high. The chip-select setup before the first falling edge, the chip-select hold after the last clock, and the quiet gap after chip select rises are each set by a count of system clocks, so the device's nanosecond minimums can be met at any system clock rate. While a frame or its quiet gap is running the block reports busy. A request that the host holds through that time is taken only once the block is idle again, so frames never overlap.

Top module: `rate_spi_master`

## Requirements
- R1: After reset, and whenever reset is asserted, even in the middle of a frame, `spi_cs_n` is 1, `spi_sclk` is 1, `spi_mosi` is 0, and `busy` and `done` are 0.
- R2: A request seen while idle is accepted at the next clock edge. `busy` and a low `spi_cs_n` appear together, and `busy` stays high while `spi_cs_n` is low. `spi_cs_n` is low with `spi_sclk` high for max(`cfg_setup`,1) cycles before the first falling edge of `spi_sclk`.
- R3: While `spi_cs_n` is low, `spi_sclk` makes exactly 16 falling and 16 rising edges. Each low phase and each high phase lasts max(`cfg_half`,1) system clocks. `spi_sclk` changes only while `spi_cs_n` is low.
- R4: The outgoing word is sent MSB first and is latched when the request is accepted. Bit 15 is `req_write`, bit 14 is 0, bits 13:12 are 0, bits 11:10 are `req_addr[1:0]`, bit 9 is `req_coding`, and bits 8:0 are 0. `spi_mosi` holds bit 15 from the fall of `spi_cs_n` and changes, within the frame, only at rising edges of `spi_sclk`.
- R5: `spi_miso` is sampled at each of the 16 rising edges of `spi_sclk`. The first sample is bit 15 of the returned word.
- R6: In the returned word, bits 15:14 are leading bits and are discarded, bits 13:12 appear on `rsp_addr`, and bits 11:0 appear on `rsp_data`. `done` pulses for one cycle in the cycle `spi_cs_n` rises, with the results already valid. The results then hold until the next `done`.
- R7: After the 16th high phase, `spi_cs_n` stays low for max(`cfg_hold`,1) further cycles.
- R8: After `spi_cs_n` rises, `busy` stays high with `spi_cs_n` high for max(`cfg_quiet`,1) cycles. It is then low for at least one cycle before another frame can start.
- R9: A request held high while `busy` is neither dropped nor overlapped. The next frame starts max(`cfg_quiet`,1)+1 cycles after `spi_cs_n` rises, using the request fields present when it is accepted.
- R10: `spi_sclk` is high in every cycle in which `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, held until busy rises |
| req_write | input | 1 | Set the control-register update bit in the outgoing word |
| req_addr | input | 2 | Channel address sent to the device |
| req_coding | input | 1 | Output-coding choice sent to the device |
| cfg_half | input | CNT_W | System clocks per serial clock phase (0 acts as 1) |
| cfg_setup | input | CNT_W | Chip-select setup cycles (0 acts as 1) |
| cfg_hold | input | CNT_W | Chip-select hold cycles after the last phase (0 acts as 1) |
| cfg_quiet | input | CNT_W | Quiet cycles after chip select rises (0 acts as 1) |
| busy | output | 1 | Frame or quiet gap in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| rsp_addr | output | 2 | Channel address echoed by the device |
| rsp_data | output | 12 | Conversion sample |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The assertions watch, on every cycle, how the pins relate to each other. The serial clock must rest high and stay still while chip select is high. The data to the device may move only on a serial rising edge. Chip select may fall only from the idle state, and busy must cover every selected cycle. Done must coincide with chip select rising, and the results may change only with done. Only the bench's scenarios can show the rest, because it depends on a whole frame. A device model counts edges and phase lengths and collects the shifted word. It also returns chosen result words, including ones whose leading bits are set. The bench checks setup, hold and quiet lengths, including counts of zero. It checks that a request held across a frame starts the next frame with the newer fields after exactly the quiet gap plus one idle cycle.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LOW   = 3'd2,
        ST_HIGH  = 3'd3,
        ST_HOLD  = 3'd4,
        ST_QUIET = 3'd5
    } rsm_state_e;

    // Position of the first control field after the write, fixed-low
    // and two unused bits at the head of the outgoing word.
    localparam int CTRL_HEAD_BITS = 4;

endpackage

// File: rtl/rsm_cmd_word.sv
module rsm_cmd_word #(
    parameter int FRAME_LEN = 16,
    parameter int ADDR_W    = 2
) (
    input  logic                 write_en,
    input  logic [ADDR_W-1:0]    chan_addr,
    input  logic                 coding_sel,
    output logic [FRAME_LEN-1:0] word
);
    import rsm_pkg::*;

    localparam int ADDR_MSB   = FRAME_LEN - 1 - CTRL_HEAD_BITS;
    localparam int CODING_POS = ADDR_MSB - ADDR_W;

    always_comb begin
        word                  = '0;
        word[FRAME_LEN-1]     = write_en;
        word[CODING_POS]      = coding_sel;
        for (int i = 0; i < ADDR_W; i++) begin
            word[CODING_POS + 1 + i] = chan_addr[i];
        end
    end
endmodule

// File: rtl/rsm_rx_unpack.sv
module rsm_rx_unpack #(
    parameter int ADDR_W   = 2,
    parameter int SAMPLE_W = 12
) (
    input  logic [ADDR_W+SAMPLE_W-1:0] payload,
    output logic [ADDR_W-1:0]          echo_addr,
    output logic [SAMPLE_W-1:0]        sample
);
    assign sample    = payload[SAMPLE_W-1:0];
    assign echo_addr = payload[ADDR_W+SAMPLE_W-1:SAMPLE_W];
endmodule

// File: rtl/rsm_seq.sv
module rsm_seq #(
    parameter int CNT_W     = 16,
    parameter int FRAME_LEN = 16,
    parameter int PAYLOAD_W = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [FRAME_LEN-1:0] tx_word,
    input  logic [CNT_W-1:0]     cfg_half,
    input  logic [CNT_W-1:0]     cfg_setup,
    input  logic [CNT_W-1:0]     cfg_hold,
    input  logic [CNT_W-1:0]     cfg_quiet,
    input  logic                 miso,
    output logic                 cs_n,
    output logic                 sclk,
    output logic                 mosi,
    output logic                 busy,
    output logic                 done,
    output logic [PAYLOAD_W-1:0] rsp_payload
);
    import rsm_pkg::*;

    localparam int              BIT_W    = $clog2(FRAME_LEN);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);

    typedef struct packed {
        rsm_state_e           state;
        logic [CNT_W-1:0]     cnt;
        logic [BIT_W-1:0]     bitn;
        logic [FRAME_LEN-1:0] tx;
        logic [PAYLOAD_W-1:0] rx;
        logic [PAYLOAD_W-1:0] rsp;
        logic                 cs_n;
        logic                 sclk;
        logic                 done;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state: ST_IDLE,
        cnt:   '0,
        bitn:  '0,
        tx:    '0,
        rx:    '0,
        rsp:   '0,
        cs_n:  1'b1,
        sclk:  1'b1,
        done:  1'b0
    };

    seq_t q, d;

    // A programmed count of N lasts max(N,1) cycles: load N-1, leave at 0.
    function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - CNT_W'(1);
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state = ST_SETUP;
                    d.cs_n  = 1'b0;
                    d.tx    = tx_word;
                    d.bitn  = '0;
                    d.cnt   = span(cfg_setup);
                end
            end
            ST_SETUP: begin
                if (q.cnt == '0) begin
                    d.state = ST_LOW;
                    d.sclk  = 1'b0;
                    d.cnt   = span(cfg_half);
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_LOW: begin
                if (q.cnt == '0) begin
                    d.state = ST_HIGH;
                    d.sclk  = 1'b1;
                    d.rx    = {q.rx[PAYLOAD_W-2:0], miso};
                    d.tx    = {q.tx[FRAME_LEN-2:0], 1'b0};
                    d.cnt   = span(cfg_half);
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_HIGH: begin
                if (q.cnt == '0) begin
                    if (q.bitn == LAST_BIT) begin
                        d.state = ST_HOLD;
                        d.cnt   = span(cfg_hold);
                    end else begin
                        d.state = ST_LOW;
                        d.sclk  = 1'b0;
                        d.bitn  = q.bitn + BIT_W'(1);
                        d.cnt   = span(cfg_half);
                    end
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (q.cnt == '0) begin
                    d.state = ST_QUIET;
                    d.cs_n  = 1'b1;
                    d.done  = 1'b1;
                    d.rsp   = q.rx;
                    d.cnt   = span(cfg_quiet);
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_QUIET: begin
                if (q.cnt == '0) begin
                    d.state = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: begin
                d = SEQ_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEQ_RST;
        end else begin
            q <= d;
        end
    end

    assign cs_n        = q.cs_n;
    assign sclk        = q.sclk;
    assign mosi        = q.tx[FRAME_LEN-1];
    assign busy        = (q.state != ST_IDLE);
    assign done        = q.done;
    assign rsp_payload = q.rsp;
endmodule

// File: rtl/rate_spi_master.sv
module rate_spi_master #(
    parameter int CNT_W    = 16,
    parameter int LEAD_W   = 2,
    parameter int ADDR_W   = 2,
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_coding,
    input  logic [CNT_W-1:0]    cfg_half,
    input  logic [CNT_W-1:0]    cfg_setup,
    input  logic [CNT_W-1:0]    cfg_hold,
    input  logic [CNT_W-1:0]    cfg_quiet,
    output logic                busy,
    output logic                done,
    output logic [ADDR_W-1:0]   rsp_addr,
    output logic [SAMPLE_W-1:0] rsp_data,
    output logic                spi_cs_n,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso
);
    localparam int PAYLOAD_W = ADDR_W + SAMPLE_W;
    localparam int FRAME_LEN = LEAD_W + PAYLOAD_W;

    logic [FRAME_LEN-1:0] ctrl_word;
    logic [PAYLOAD_W-1:0] payload;

    rsm_cmd_word #(
        .FRAME_LEN (FRAME_LEN),
        .ADDR_W    (ADDR_W)
    ) u_cmd (
        .write_en   (req_write),
        .chan_addr  (req_addr),
        .coding_sel (req_coding),
        .word       (ctrl_word)
    );

    rsm_seq #(
        .CNT_W     (CNT_W),
        .FRAME_LEN (FRAME_LEN),
        .PAYLOAD_W (PAYLOAD_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (req),
        .tx_word     (ctrl_word),
        .cfg_half    (cfg_half),
        .cfg_setup   (cfg_setup),
        .cfg_hold    (cfg_hold),
        .cfg_quiet   (cfg_quiet),
        .miso        (spi_miso),
        .cs_n        (spi_cs_n),
        .sclk        (spi_sclk),
        .mosi        (spi_mosi),
        .busy        (busy),
        .done        (done),
        .rsp_payload (payload)
    );

    rsm_rx_unpack #(
        .ADDR_W   (ADDR_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_unpack (
        .payload   (payload),
        .echo_addr (rsp_addr),
        .sample    (rsp_data)
    );
endmodule

// File: rtl/rsm_checker.sv
module rsm_checker #(
    parameter int ADDR_W   = 2,
    parameter int SAMPLE_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                done,
    input logic [ADDR_W-1:0]   rsp_addr,
    input logic [SAMPLE_W-1:0] rsp_data,
    input logic                spi_cs_n,
    input logic                spi_sclk,
    input logic                spi_mosi
);
    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_sclk); // R10

    AST_SCLK_MOVES_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_sclk) |-> !spi_cs_n); // R3

    AST_MOSI_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(!spi_cs_n) && !$stable(spi_mosi)) |-> $rose(spi_sclk)); // R4

    AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy); // R2

    AST_CS_FALL_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> !$past(busy)); // R9

    AST_DONE_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(spi_cs_n)); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rsp_data) || !$stable(rsp_addr)) |-> done); // R6
endmodule

bind rate_spi_master rsm_checker #(
    .ADDR_W   (ADDR_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .rsp_addr (rsp_addr),
    .rsp_data (rsp_data),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi)
);

// File: tb/sim_rate_spi_master.sv
module sim_rate_spi_master;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int NVEC       = 6;

    // {write, addr[1:0], coding, resp[15:0], half, setup, hold, quiet}
    localparam logic [35:0] VEC [NVEC] = '{
        {1'b1, 2'd2, 1'b0, 16'h2A5C, 4'd2, 4'd3, 4'd2, 4'd4},
        {1'b0, 2'd1, 1'b1, 16'h13F0, 4'd1, 4'd1, 4'd1, 4'd1},
        {1'b1, 2'd3, 1'b1, 16'h3FFF, 4'd3, 4'd2, 4'd3, 4'd2},
        {1'b0, 2'd0, 1'b0, 16'h0001, 4'd0, 4'd0, 4'd0, 4'd0},
        {1'b1, 2'd0, 1'b1, 16'h0800, 4'd4, 4'd5, 4'd1, 4'd6},
        {1'b0, 2'd2, 1'b1, 16'hE123, 4'd1, 4'd2, 4'd2, 4'd3}
    };

    logic             clk, rst_n;
    logic             req, req_write, req_coding;
    logic [1:0]       req_addr;
    logic [CNT_W-1:0] cfg_half, cfg_setup, cfg_hold, cfg_quiet;
    logic             busy, done;
    logic [1:0]       rsp_addr;
    logic [11:0]      rsp_data;
    logic             spi_cs_n, spi_sclk, spi_mosi, spi_miso;

    rate_spi_master u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_coding(req_coding),
        .cfg_half(cfg_half), .cfg_setup(cfg_setup),
        .cfg_hold(cfg_hold), .cfg_quiet(cfg_quiet),
        .busy(busy), .done(done), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check_eq(input string tag, input string what,
                            input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int at_least_one(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // ---------------- device model ----------------
    logic [15:0] dev_resp [0:3];
    logic [15:0] dev_hist [0:3];
    logic [15:0] dev_word;
    int          dev_falls, dev_rises, dev_frames;

    initial begin
        spi_miso = 1'b0;
        dev_falls = 0; dev_rises = 0; dev_frames = 0; dev_word = '0;
        for (int i = 0; i < 4; i++) begin
            dev_resp[i] = '0;
            dev_hist[i] = '0;
        end
    end

    initial forever begin
        @(negedge spi_cs_n);
        dev_falls = 0;
        dev_rises = 0;
        dev_word  = '0;
    end

    initial forever begin
        @(negedge spi_sclk);
        if (spi_cs_n == 1'b0) begin
            dev_word = {dev_word[14:0], spi_mosi};
            if (dev_falls < 16)
                spi_miso = dev_resp[dev_frames % 4][15 - dev_falls];
            dev_falls++;
        end
    end

    initial forever begin
        @(posedge spi_sclk);
        if (spi_cs_n == 1'b0) dev_rises++;
    end

    initial forever begin
        @(posedge spi_cs_n);
        if (rst_n === 1'b1) begin
            dev_hist[dev_frames % 4] = dev_word;
            dev_frames++;
        end
    end

    // ---------------- pin monitor ----------------
    int m_setup, m_low, m_tail, m_quiet, m_done, m_done_sel, m_badidle;
    int m_run, m_last_gap;
    logic [11:0] m_data;
    logic [1:0]  m_addr;

    task automatic clear_monitor();
        m_setup = 0; m_low = 0; m_tail = 0; m_quiet = 0;
        m_done = 0; m_done_sel = 0; m_badidle = 0; m_last_gap = -1;
        dev_frames = 0;
    endtask

    initial begin
        m_run = 0;
        clear_monitor();
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!spi_cs_n && spi_sclk && dev_falls == 0) m_setup++;
                if (!spi_cs_n && !spi_sclk) m_low++;
                if (!spi_cs_n && spi_sclk && dev_falls == 16) m_tail++;
                if (spi_cs_n && busy) m_quiet++;
                if (spi_cs_n && !spi_sclk) m_badidle++;
                if (done) begin
                    m_done++;
                    if (!spi_cs_n) m_done_sel++;
                    m_data = rsp_data;
                    m_addr = rsp_addr;
                end
                if (spi_cs_n) m_run++;
                else begin
                    if (m_run > 0) m_last_gap = m_run;
                    m_run = 0;
                end
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    initial begin
        rst_n = 1'b0; req = 1'b0; req_write = 1'b0; req_addr = '0; req_coding = 1'b0;
        cfg_half = 16'd1; cfg_setup = 16'd1; cfg_hold = 16'd1; cfg_quiet = 16'd1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1", "cs_n after reset", spi_cs_n, 1);
        check_eq("R1", "sclk after reset", spi_sclk, 1);
        check_eq("R1", "mosi after reset", spi_mosi, 0);
        check_eq("R1", "busy after reset", busy, 0);
        check_eq("R1", "done after reset", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R1", "idle busy", busy, 0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            logic        w, c;
            logic [1:0]  a;
            logic [15:0] resp, exp_word;
            int          h, s, hd, qt;
            w    = VEC[v][35];
            a    = VEC[v][34:33];
            c    = VEC[v][32];
            resp = VEC[v][31:16];
            h    = int'(VEC[v][15:12]);
            s    = int'(VEC[v][11:8]);
            hd   = int'(VEC[v][7:4]);
            qt   = int'(VEC[v][3:0]);
            exp_word = {w, 1'b0, 2'b00, a, c, 9'b0};
            clear_monitor();
            dev_resp[0] = resp;
            cfg_half = CNT_W'(h); cfg_setup = CNT_W'(s);
            cfg_hold = CNT_W'(hd); cfg_quiet = CNT_W'(qt);
            req_write = w; req_addr = a; req_coding = c; req = 1'b1;
            @(negedge clk);
            check_eq("R2", "busy after accept", busy, 1);
            check_eq("R2", "cs_n after accept", spi_cs_n, 0);
            req = 1'b0;
            wait_idle();
            check_eq("R4", "outgoing word", dev_hist[0], exp_word);
            check_eq("R3", "falling edges", dev_falls, 16);
            check_eq("R3", "rising edges", dev_rises, 16);
            check_eq("R3", "low phase cycles", m_low, 16 * at_least_one(h));
            check_eq("R2", "setup cycles", m_setup, at_least_one(s));
            check_eq("R7", "tail cycles", m_tail, at_least_one(h) + at_least_one(hd));
            check_eq("R8", "quiet cycles", m_quiet, at_least_one(qt));
            check_eq("R6", "done pulses", m_done, 1);
            check_eq("R6", "done while selected", m_done_sel, 0);
            check_eq("R5", "sample at done", m_data, resp[11:0]);
            check_eq("R6", "echo addr at done", m_addr, resp[13:12]);
            check_eq("R10", "sclk low while deselected", m_badidle, 0);
            repeat (3) @(negedge clk);
            check_eq("R6", "sample held", rsp_data, resp[11:0]);
            check_eq("R6", "addr held", rsp_addr, resp[13:12]);
        end

        // R9: request held across a frame, fields changed mid-frame
        clear_monitor();
        dev_resp[0] = 16'h1111; dev_resp[1] = 16'h2222;
        cfg_half = 16'd1; cfg_setup = 16'd1; cfg_hold = 16'd1; cfg_quiet = 16'd3;
        req_write = 1'b0; req_addr = 2'd1; req_coding = 1'b0; req = 1'b1;
        @(negedge clk);
        repeat (5) @(negedge clk);
        req_write = 1'b1; req_addr = 2'd2;
        do @(negedge clk); while (m_done < 1);
        while (busy) @(negedge clk);
        @(negedge clk);
        check_eq("R9", "second frame accepted", busy, 1);
        req = 1'b0;
        wait_idle();
        check_eq("R9", "frames sent", dev_frames, 2);
        check_eq("R9", "first word kept", dev_hist[0], 16'h0400);
        check_eq("R9", "second word new fields", dev_hist[1], 16'h8800);
        check_eq("R9", "deselect gap", m_last_gap, 3 + 1);
        check_eq("R8", "quiet cycles over two frames", m_quiet, 6);
        check_eq("R9", "done pulses", m_done, 2);
        check_eq("R6", "second result", rsp_data, 12'h222);

        // R1: reset in the middle of a frame
        cfg_half = 16'd3;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_eq("R1", "cs_n on mid-frame reset", spi_cs_n, 1);
        check_eq("R1", "sclk on mid-frame reset", spi_sclk, 1);
        check_eq("R1", "mosi on mid-frame reset", spi_mosi, 0);
        check_eq("R1", "busy on mid-frame reset", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule